// File: doc/BRIEF.md
# Binary to Packed Decimal Store Unit

This block takes a signed 64-bit two's-complement integer, the value already rounded from the top of the register stack, and writes it out as a ten-byte packed decimal record. Eighteen decimal digits are packed two to a byte in bytes 0 to 8, lowest digit first. Byte 9 carries the sign.

The conversion is iterative. The sign is recorded and the magnitude is captured when the request is accepted. After that, each step divides the magnitude by ten and keeps the remainder as the next digit. A pair of digits becomes one byte write on a simple byte port, which carries an offset, data and a strobe.

A single-cycle start request launches the store. Busy stays high while the store runs. Done pulses once the sign byte has been written, and a pop request to the stack goes with it. A magnitude that needs more than eighteen digits is rejected at once with an overflow flag, and nothing is written.

Top module: `bcd_store_unit`

## Requirements
- R1: While reset is high and in the first cycle after it is released, busy_o, done_o, ovf_o, pop_o and wr_en_o are all low.
- R2: An accepted store of an in-range value produces exactly ten strobes on wr_en_o, at offsets 0, 1, 2, … 9 in ascending order, with one byte per strobe.
- R3: If the magnitude of value_i exceeds 999,999,999,999,999,999, the unit asserts ovf_o and done_o together in the cycle after start_i is accepted. This includes the most negative 64-bit value. In that case it makes no write strobe, raises no pop_o and keeps busy_o low.
- R4: For k in 0..8, the byte at offset k holds decimal digit 2k of the magnitude in bits 3:0 and digit 2k+1 in bits 7:4, where digit 0 is the least significant. Every such nibble is 0 to 9.
- R5: The byte at offset 9 has bit 7 set exactly when value_i was negative, and bits 6:0 are zero. Zero is stored with a clear sign bit.
- R6: done_o is high for one cycle, in the cycle right after the offset-9 strobe, and pop_o is high in exactly that cycle.
- R7: busy_o is high from the cycle after an accepted start through the cycle of the offset-9 strobe. It is low in the done_o cycle.
- R8: A start_i raised while busy_o is high is ignored, and the bytes written still describe the value that started the store.
- R9: A start_i raised in the same cycle as done_o is accepted, so stores can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Store request, accepted when busy_o is low |
| value_i | input | 64 | Signed integer to store, sampled with start_i |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Out-of-range magnitude, pulses with done_o |
| pop_o | output | 1 | Stack pop request after a completed store |
| wr_en_o | output | 1 | Byte write strobe |
| wr_addr_o | output | 4 | Byte offset within the record |
| wr_data_o | output | 8 | Byte data |

## Verification
Two things can land in one cycle: the completion pulse of one store and the acceptance of the next request. The bench provokes this by raising start_i in the very cycle where it sees done_o. It does so after normal stores and after an overflow rejection. It judges the result by checking that the second store writes its own full, correct record and finishes with its own done and pop. A request poked in the middle of a running store must leave that store's bytes unchanged.

// File: rtl/bcdst_pkg.sv
package bcdst_pkg;

    localparam int VAL_W   = 64;
    localparam int DIGITS  = 18;
    localparam int ADDR_W  = 4;
    localparam int BYTE_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_SIGN,
        ST_FIN
    } seq_state_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_beat_t;

    // Largest magnitude representable with the given number of digits
    function automatic logic [VAL_W-1:0] max_mag(input int digits);
        logic [VAL_W-1:0] p;
        p = VAL_W'(1);
        for (int i = 0; i < digits; i++) begin
            p = p * VAL_W'(10);
        end
        return p - VAL_W'(1);
    endfunction

endpackage

// File: rtl/bcdst_front.sv
module bcdst_front
    import bcdst_pkg::*;
#(
    parameter int W      = VAL_W,
    parameter int NDIGIT = DIGITS
) (
    input  logic [W-1:0] value,
    output logic         neg,
    output logic [W-1:0] mag,
    output logic         too_big
);
    localparam logic [W-1:0] LIMIT = W'(max_mag(NDIGIT));

    always_comb begin
        neg     = value[W-1];
        mag     = neg ? (-value) : value;
        too_big = (mag > LIMIT);
    end
endmodule

// File: rtl/bcdst_digit.sv
module bcdst_digit #(
    parameter int W = 64
) (
    input  logic [W-1:0] mag,
    output logic [W-1:0] quo,
    output logic [3:0]   rem
);
    always_comb begin
        quo = mag / W'(10);
        rem = 4'(mag % W'(10));
    end
endmodule

// File: rtl/bcdst_seq.sv
module bcdst_seq
    import bcdst_pkg::*;
#(
    parameter int W      = VAL_W,
    parameter int NDIGIT = DIGITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         neg_in,
    input  logic [W-1:0] mag_in,
    input  logic         too_big,
    input  logic [W-1:0] quo,
    input  logic [3:0]   rem,
    output logic [W-1:0] mag_q,
    output logic         busy,
    output logic         done,
    output logic         ovf,
    output logic         pop,
    output wr_beat_t     beat
);
    localparam int DBYTES = NDIGIT / 2;
    localparam logic [ADDR_W-1:0] LAST_D = ADDR_W'(DBYTES - 1);
    localparam logic [ADDR_W-1:0] SIGN_A = ADDR_W'(DBYTES);

    seq_state_t        state;
    logic              neg_q;
    logic [3:0]        lo_q;
    logic [ADDR_W-1:0] idx;

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            mag_q <= '0;
            neg_q <= 1'b0;
            lo_q  <= '0;
            idx   <= '0;
            beat  <= '0;
            done  <= 1'b0;
            ovf   <= 1'b0;
            pop   <= 1'b0;
        end else begin
            beat.en <= 1'b0;
            done    <= 1'b0;
            ovf     <= 1'b0;
            pop     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (too_big) begin
                            done <= 1'b1;
                            ovf  <= 1'b1;
                        end else begin
                            mag_q <= mag_in;
                            neg_q <= neg_in;
                            idx   <= '0;
                            state <= ST_LO;
                        end
                    end
                end
                ST_LO: begin
                    lo_q  <= rem;
                    mag_q <= quo;
                    state <= ST_HI;
                end
                ST_HI: begin
                    mag_q     <= quo;
                    beat.en   <= 1'b1;
                    beat.addr <= idx;
                    beat.data <= {rem, lo_q};
                    idx       <= idx + 1'b1;
                    state     <= (idx == LAST_D) ? ST_SIGN : ST_LO;
                end
                ST_SIGN: begin
                    beat.en   <= 1'b1;
                    beat.addr <= SIGN_A;
                    beat.data <= {neg_q, 7'b0};
                    state     <= ST_FIN;
                end
                ST_FIN: begin
                    done  <= 1'b1;
                    pop   <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bcd_store_unit.sv
module bcd_store_unit
    import bcdst_pkg::*;
#(
    parameter int W      = VAL_W,
    parameter int NDIGIT = DIGITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [W-1:0]      value_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic              pop_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    logic         neg_in;
    logic [W-1:0] mag_in;
    logic         too_big;
    logic [W-1:0] mag_q;
    logic [W-1:0] quo;
    logic [3:0]   rem;
    wr_beat_t     beat;

    bcdst_front #(.W(W), .NDIGIT(NDIGIT)) u_front (
        .value   (value_i),
        .neg     (neg_in),
        .mag     (mag_in),
        .too_big (too_big)
    );

    bcdst_digit #(.W(W)) u_digit (
        .mag (mag_q),
        .quo (quo),
        .rem (rem)
    );

    bcdst_seq #(.W(W), .NDIGIT(NDIGIT)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .neg_in  (neg_in),
        .mag_in  (mag_in),
        .too_big (too_big),
        .quo     (quo),
        .rem     (rem),
        .mag_q   (mag_q),
        .busy    (busy_o),
        .done    (done_o),
        .ovf     (ovf_o),
        .pop     (pop_o),
        .beat    (beat)
    );

    assign wr_en_o   = beat.en;
    assign wr_addr_o = beat.addr;
    assign wr_data_o = beat.data;
endmodule

// File: rtl/bcd_store_unit_chk.sv
module bcd_store_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy_o,
    input logic       done_o,
    input logic       ovf_o,
    input logic       pop_o,
    input logic       wr_en_o,
    input logic [3:0] wr_addr_o,
    input logic [7:0] wr_data_o
);
    p_wr_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> busy_o);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (done_o && !wr_en_o && !pop_o && !busy_o));

    p_nibble_range_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && wr_addr_o < 4'd9) |-> (wr_data_o[3:0] <= 4'd9 && wr_data_o[7:4] <= 4'd9));

    p_sign_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && wr_addr_o == 4'd9) |-> (wr_data_o[6:0] == 7'd0));

    p_done_after_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && wr_addr_o == 4'd9) |=> (done_o && pop_o));

    p_pop_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        pop_o |-> (done_o && !ovf_o));

    p_idle_at_done_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

bind bcd_store_unit bcd_store_unit_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ovf_o     (ovf_o),
    .pop_o     (pop_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
);

// File: tb/test_bcd_store_unit.sv
module test_bcd_store_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [63:0] value_i;
    logic        busy_o, done_o, ovf_o, pop_o, wr_en_o;
    logic [3:0]  wr_addr_o;
    logic [7:0]  wr_data_o;

    int tests = 0;
    int fails = 0;

    localparam logic [63:0] LIM = 64'd999999999999999999;

    always #5 clk = ~clk;

    bcd_store_unit i_bcd_store_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i),
        .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o), .pop_o(pop_o),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected record: bytes 0..9 packed little end first
    function automatic void model(input logic [63:0] v, output bit ovf,
                                  output logic [79:0] rec);
        logic [63:0] m;
        logic [3:0]  d0, d1;
        m   = v[63] ? (64'd0 - v) : v;
        ovf = (m > LIM);
        rec = '0;
        for (int k = 0; k < 9; k++) begin
            d0 = 4'(m % 64'd10); m = m / 64'd10;
            d1 = 4'(m % 64'd10); m = m / 64'd10;
            rec[8*k +: 8] = {d1, d0};
        end
        rec[79:72] = {v[63], 7'd0};
    endfunction

    // Called at a negedge; leaves start low at the next negedge
    task automatic launch(input logic [63:0] v);
        start_i = 1'b1;
        value_i = v;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Samples from the current negedge until done; poke_at>=0 raises start mid-store (R8)
    task automatic collect(input logic [63:0] v, input int poke_at, input logic [63:0] poke_v);
        bit          eovf, got_done, ovf_seen, pop_ok, busy_ok, order_ok, lat_ok;
        logic [79:0] erec, grec;
        int          n, last_wr;
        model(v, eovf, erec);
        grec = '0; n = 0; last_wr = -10;
        got_done = 0; ovf_seen = 0; pop_ok = 1; busy_ok = 1; order_ok = 1; lat_ok = 1;
        for (int c = 0; c < 60; c++) begin
            if (c == poke_at) begin start_i = 1'b1; value_i = poke_v; end
            if (c == poke_at + 1) begin start_i = 1'b0; value_i = v; end
            if (wr_en_o) begin
                if (n < 10) begin
                    if (wr_addr_o != 4'(n)) order_ok = 0;
                    grec[8*n +: 8] = wr_data_o;
                end
                n++;
                last_wr = c;
            end
            if (done_o) begin
                got_done = 1;
                ovf_seen = ovf_o;
                if (pop_o == eovf) pop_ok = 0;
                if (busy_o) busy_ok = 0;
                if (!eovf && last_wr != c - 1) lat_ok = 0;
                break;
            end
            if (!eovf && !busy_o) busy_ok = 0;
            if (eovf && busy_o) busy_ok = 0;
            @(negedge clk);
        end
        chk(got_done, "R6", "done seen", 64'(got_done), 64'd1);
        chk(ovf_seen == eovf, "R3", "overflow flag", 64'(ovf_seen), 64'(eovf));
        chk(pop_ok, "R6", "pop matches done", 64'(pop_o), 64'(!eovf));
        chk(busy_ok, "R7", "busy window", 64'(busy_o), 64'(!eovf));
        if (eovf) begin
            chk(n == 0, "R3", "no strobes on overflow", 64'(n), 64'd0);
        end else begin
            chk(n == 10 && order_ok, "R2", "strobe count/order", 64'(n), 64'd10);
            chk(grec[71:0] == erec[71:0], "R4", "digit bytes low", grec[63:0], erec[63:0]);
            chk(grec[71:64] == erec[71:64], "R4", "digit byte 8", 64'(grec[71:64]), 64'(erec[71:64]));
            chk(grec[79:72] == erec[79:72], "R5", "sign byte", 64'(grec[79:72]), 64'(erec[79:72]));
            chk(lat_ok, "R6", "done one cycle after last byte", 64'(last_wr), 64'd0);
        end
    endtask

    task automatic store(input logic [63:0] v);
        @(negedge clk);
        launch(v);
        collect(v, -5, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] r;
        int          seed;
        seed = 11;
        void'($urandom(seed));
        start_i = 1'b0; value_i = '0; rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({busy_o, done_o, ovf_o, pop_o, wr_en_o} == 5'b0, "R1", "outputs in reset",
            64'({busy_o, done_o, ovf_o, pop_o, wr_en_o}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy_o, done_o, ovf_o, pop_o, wr_en_o} == 5'b0, "R1", "outputs after reset",
            64'({busy_o, done_o, ovf_o, pop_o, wr_en_o}), 64'd0);

        // Directed corners (R2..R7)
        store(64'd0);
        store(64'd1);
        store(-64'd1);
        store(64'd123456789012345678);
        store(LIM);
        store(-LIM);
        store(LIM + 64'd1);            // R3
        store(-(LIM + 64'd1));         // R3
        store(64'h8000_0000_0000_0000); // R3 most negative
        store(64'h7fff_ffff_ffff_ffff); // R3

        // R8: start while busy must be ignored
        @(negedge clk);
        launch(64'd987654321);
        collect(64'd987654321, 3, -64'd55);

        // R9: start in the done cycle, after a normal store and after an overflow
        @(negedge clk);
        launch(64'd42);
        collect(64'd42, -5, 64'd0);
        launch(-64'd700000000000000001);
        collect(-64'd700000000000000001, -5, 64'd0);
        launch(LIM + 64'd7);
        collect(LIM + 64'd7, -5, 64'd0);
        launch(64'd31415926535);
        collect(64'd31415926535, -5, 64'd0);

        // Constrained random mix
        for (int i = 0; i < 60; i++) begin
            r = {$urandom, $urandom};
            case (i % 4)
                0: r = r % (LIM + 64'd1);
                1: r = 64'd0 - (r % (LIM + 64'd1));
                2: r = r % 64'd100000;
                default: ;
            endcase
            store(r);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule